// File: doc/BRIEF.md
# ADC Result Threshold Comparator and Accumulator

This block sits behind a converter and post-processes its stream of signed results. Each sample that arrives with the valid strobe high has its sign-independent magnitude compared with a programmable threshold. Depending on the comparator mode, the block either raises a one-cycle exceedance flag or counts samples that fall on a chosen side of the threshold. A sticky event flag rises when that count reaches a programmed target.

The same sample stream also feeds a wide accumulator. The accumulator adds or subtracts each valid sample, sign-extended, and its running value is presented directly on an output port.

The count target and the accumulator mode are held in registers inside the block and are loaded by write strobes. The threshold and the comparator mode are plain inputs, supplied from registers elsewhere.

Top module: `adc_thresh_acc`

## Requirements
- R1: After reset, acc_value, cnt_value, over_evt and cnt_evt are all zero. The stored count target and the stored accumulator mode are also zero.
- R2: When cmp_mode is 2'b01 and a valid sample's magnitude is strictly greater than threshold, over_evt is 1 for exactly the next cycle. A magnitude equal to or below the threshold, any other mode, or smp_valid low gives over_evt 0.
- R3: The magnitude is the two's-complement absolute value of smp_data. The most negative code (MSB 1, all other bits 0) gives the largest positive value, 2^(SAMPLE_W-1)-1, and never wraps.
- R4: With cmp_mode 2'b10, each valid sample whose magnitude is strictly above threshold increments cnt_value. With 2'b11, each valid sample whose magnitude is strictly below threshold increments it. Modes 2'b00 and 2'b01 never change the counter.
- R5: cnt_value never exceeds the stored target. A qualifying sample that brings the count to the target sets cnt_evt, and so does any qualifying sample while the count already equals the target; with a target of 0 this means the first qualifying sample sets it. Once set, cnt_evt stays 1 until the target is rewritten.
- R6: A cycle with cnt_target_wr high loads cnt_target_in and clears cnt_value and cnt_evt. This takes priority over any sample in the same cycle.
- R7: The stored accumulator mode works as follows. 2'b01 adds the sign-extended sample on each valid cycle. 2'b10 subtracts it. 2'b00 and 2'b11 leave acc_value unchanged.
- R8: A cycle with acc_mode_wr high loads acc_mode_in and clears acc_value to 0. This takes priority over any sample in the same cycle.
- R9: acc_value wraps modulo 2^ACC_W on overflow and on underflow.
- R10: With smp_valid, cnt_target_wr and acc_mode_wr all low, acc_value, cnt_value and cnt_evt keep their values and over_evt is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed sample, two's complement |
| threshold | input | SAMPLE_W | Unsigned magnitude threshold |
| cmp_mode | input | 2 | Comparator mode: 00 off, 01 flag, 10 count above, 11 count below |
| acc_mode_in | input | 2 | Accumulator mode to load: 00 off, 01 add, 10 subtract, 11 hold |
| acc_mode_wr | input | 1 | Load accumulator mode and clear accumulator |
| cnt_target_in | input | CNT_W | Count target to load |
| cnt_target_wr | input | 1 | Load count target and clear counter and event |
| acc_value | output | ACC_W | Running accumulator |
| cnt_value | output | CNT_W | Threshold event count |
| over_evt | output | 1 | One-cycle exceedance flag |
| cnt_evt | output | 1 | Sticky count-reached flag |

## Verification
The bench builds the block with SAMPLE_W=8, CNT_W=4 and ACC_W=12. These sizes make the most negative code (8'h80) common in random stimulus. They also let the counter reach targets of up to 15 within a few dozen samples, so saturation and the sticky flag occur often. With a 12-bit accumulator, additions and subtractions of 8-bit samples overflow and underflow often, so the wrap is exercised in both directions.

// File: rtl/adc_thresh_acc.sv
module adc_thresh_acc #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 16,
  parameter int ACC_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [1:0]          cmp_mode,
  input  logic [1:0]          acc_mode_in,
  input  logic                acc_mode_wr,
  input  logic [CNT_W-1:0]    cnt_target_in,
  input  logic                cnt_target_wr,
  output logic [ACC_W-1:0]    acc_value,
  output logic [CNT_W-1:0]    cnt_value,
  output logic                over_evt,
  output logic                cnt_evt
);

  localparam logic [SAMPLE_W-1:0] MAG_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic [SAMPLE_W-1:0] mag;
  logic                is_min;
  logic                above, below, count_hit, at_target;
  logic [CNT_W-1:0]    tgt_q, cnt_inc;
  logic [1:0]          amode_q;
  logic [ACC_W-1:0]    smp_ext;

  assign is_min    = smp_data[SAMPLE_W-1] && (smp_data[SAMPLE_W-2:0] == '0);
  assign mag       = is_min ? MAG_MAX :
                     smp_data[SAMPLE_W-1] ? (~smp_data + 1'b1) : smp_data;
  assign above     = mag > threshold;
  assign below     = mag < threshold;
  assign count_hit = smp_valid && ((cmp_mode == 2'b10 && above) ||
                                   (cmp_mode == 2'b11 && below));
  assign at_target = cnt_value == tgt_q;
  assign cnt_inc   = cnt_value + 1'b1;
  assign smp_ext   = ACC_W'($signed(smp_data));

  always_ff @(posedge clk) begin
    if (!rst_n) over_evt <= 1'b0;
    else        over_evt <= smp_valid && cmp_mode == 2'b01 && above;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q     <= '0;
      cnt_value <= '0;
      cnt_evt   <= 1'b0;
    end else if (cnt_target_wr) begin
      tgt_q     <= cnt_target_in;
      cnt_value <= '0;
      cnt_evt   <= 1'b0;
    end else if (count_hit) begin
      if (!at_target) cnt_value <= cnt_inc;
      if (at_target || cnt_inc == tgt_q) cnt_evt <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amode_q   <= 2'b00;
      acc_value <= '0;
    end else if (acc_mode_wr) begin
      amode_q   <= acc_mode_in;
      acc_value <= '0;
    end else if (smp_valid) begin
      case (amode_q)
        2'b01:   acc_value <= acc_value + smp_ext;
        2'b10:   acc_value <= acc_value - smp_ext;
        default: acc_value <= acc_value;
      endcase
    end
  end

  assert_cnt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_value <= tgt_q);
  assert_evt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_evt && !cnt_target_wr |=> cnt_evt);
  assert_tgt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_target_wr |=> cnt_value == '0 && !cnt_evt);
  assert_acc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mode_wr |=> acc_value == '0);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid && !cnt_target_wr && !acc_mode_wr |=>
      $stable(acc_value) && $stable(cnt_value) && $stable(cnt_evt) && !over_evt);
  assert_mag_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mag[SAMPLE_W-1]);

endmodule

// File: tb/adc_thresh_acc_bench.sv
module adc_thresh_acc_bench;
  localparam int SW = 8, CW = 4, AW = 12;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, acc_mode_wr = 0, cnt_target_wr = 0;
  logic [SW-1:0] smp_data = '0, threshold = '0;
  logic [1:0] cmp_mode = '0, acc_mode_in = '0;
  logic [CW-1:0] cnt_target_in = '0;
  logic [AW-1:0] acc_value;
  logic [CW-1:0] cnt_value;
  logic over_evt, cnt_evt;

  int n_run = 0, n_fail = 0;
  logic [AW-1:0] m_acc;
  logic [CW-1:0] m_cnt, m_tgt;
  logic [1:0] m_amode;
  logic m_over, m_evt;

  always #5 clk = ~clk;

  adc_thresh_acc #(.SAMPLE_W(SW), .CNT_W(CW), .ACC_W(AW)) u_adc_thresh_acc (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .threshold(threshold), .cmp_mode(cmp_mode), .acc_mode_in(acc_mode_in),
    .acc_mode_wr(acc_mode_wr), .cnt_target_in(cnt_target_in),
    .cnt_target_wr(cnt_target_wr), .acc_value(acc_value), .cnt_value(cnt_value),
    .over_evt(over_evt), .cnt_evt(cnt_evt));

  function automatic logic [SW-1:0] mag_f(logic [SW-1:0] d);
    int v = $signed(d);
    if (v < 0) v = -v;
    if (v > 127) v = 127;
    return SW'(v);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [SW-1:0] m = mag_f(smp_data);
    logic hit;
    m_over = smp_valid && cmp_mode == 2'b01 && m > threshold;
    hit = smp_valid && ((cmp_mode == 2'b10 && m > threshold) ||
                        (cmp_mode == 2'b11 && m < threshold));
    if (cnt_target_wr) begin
      m_tgt = cnt_target_in; m_cnt = 0; m_evt = 0;
    end else if (hit) begin
      if (m_cnt != m_tgt) m_cnt = m_cnt + 1;
      if (m_cnt == m_tgt) m_evt = 1;
    end
    if (acc_mode_wr) begin
      m_amode = acc_mode_in; m_acc = 0;
    end else if (smp_valid) begin
      if (m_amode == 2'b01) m_acc = m_acc + AW'($signed(smp_data));
      else if (m_amode == 2'b10) m_acc = m_acc - AW'($signed(smp_data));
    end
  endtask

  task automatic step_check();
    @(posedge clk);
    model_step();
    #1;
    chk("R7/R9 acc", int'(acc_value), int'(m_acc));
    chk("R4/R5 cnt", int'(cnt_value), int'(m_cnt));
    chk("R5/R6 cnt_evt", int'(cnt_evt), int'(m_evt));
    chk("R2/R3 over_evt", int'(over_evt), int'(m_over));
    @(negedge clk);
    smp_valid = 0; acc_mode_wr = 0; cnt_target_wr = 0;
  endtask

  task automatic drive(logic v, logic [SW-1:0] d);
    smp_valid = v; smp_data = d;
    step_check();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_acc = 0; m_cnt = 0; m_tgt = 0; m_amode = 0; m_over = 0; m_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 acc", int'(acc_value), 0);
    chk("R1 cnt", int'(cnt_value), 0);
    chk("R1 over", int'(over_evt), 0);
    chk("R1 evt", int'(cnt_evt), 0);
    @(negedge clk);

    // R3: most negative code gives 127
    cmp_mode = 2'b01; threshold = 8'd126;
    drive(1, 8'h80);
    chk("R3 min code above 126", int'(over_evt), 1);
    threshold = 8'd127;
    drive(1, 8'h80);
    chk("R3 min code not above 127", int'(over_evt), 0);
    // R2: equal does not flag
    threshold = 8'd20;
    drive(1, 8'hEC);
    chk("R2 equal magnitude", int'(over_evt), 0);
    drive(1, 8'hEB);
    chk("R2 magnitude 21", int'(over_evt), 1);

    // R5/R6: saturation at target 3
    cnt_target_in = 4'd3; cnt_target_wr = 1; step_check();
    cmp_mode = 2'b10; threshold = 8'd0;
    for (int i = 0; i < 5; i++) drive(1, 8'd5);
    chk("R5 saturated count", int'(cnt_value), 3);
    chk("R5 evt held", int'(cnt_evt), 1);
    // R10: valid low changes nothing
    drive(0, 8'd5);
    chk("R10 cnt held", int'(cnt_value), 3);
    cnt_target_in = 4'd9; cnt_target_wr = 1; drive(1, 8'd5);
    chk("R6 cnt cleared", int'(cnt_value), 0);
    chk("R6 evt cleared", int'(cnt_evt), 0);

    // R8/R9: clear then add 127 33 times -> 4191 mod 4096 = 95
    acc_mode_in = 2'b01; acc_mode_wr = 1; drive(1, 8'd50);
    chk("R8 acc cleared", int'(acc_value), 0);
    for (int i = 0; i < 33; i++) drive(1, 8'd127);
    chk("R9 wrap", int'(acc_value), 95);
    acc_mode_in = 2'b11; acc_mode_wr = 1; step_check();
    drive(1, 8'd9);
    chk("R7 reserved mode holds", int'(acc_value), 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] r = 8'($urandom);
      smp_valid = ($urandom % 10) < 7;
      smp_data = (r < 8'd12) ? 8'h80 : (r < 8'd20) ? threshold : 8'($urandom);
      if ($urandom % 40 == 0) threshold = 8'($urandom % 128);
      if ($urandom % 60 == 0) cmp_mode = 2'($urandom);
      if ($urandom % 50 == 0) begin cnt_target_wr = 1; cnt_target_in = 4'($urandom); end
      if ($urandom % 70 == 0) begin acc_mode_wr = 1; acc_mode_in = 2'($urandom); end
      step_check();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule